// File: doc/BRIEF.md
# Shift and Rotate Execution Unit

A purely combinational unit that performs the bit-shift operations of a classic 32-bit RISC integer pipeline. The main decoder hands it the function code of a register-format shift instruction, the two five-bit instruction fields that can carry an amount or a mode bit, the register value that supplies a variable amount, and the operand to be shifted. In the same cycle the unit returns the shifted word and a flag that marks an encoding it does not accept.

There are four kinds of operation: left shift with zero fill, right shift with zero fill, right shift with sign fill, and rotate right. Each kind comes in an immediate-amount form and a register-amount form. Rotate right has no function code of its own. It reuses the code of the matching right logical shift and is chosen by a single mode bit. That bit sits in the low bit of the instruction's register field (instruction bit 21) for the immediate form, and in the low bit of the amount field (instruction bit 6) for the register form. Fetch, register-file access and writeback happen outside this unit.

Top module: `shrot_unit`

## Requirements
- R1: Function code 0x00 with `reg_field` equal to zero shifts `operand` left by `imm_field` and fills the vacated low bits with zeros.
- R2: Function code 0x02 shifts `operand` right by `imm_field` with zero fill when `reg_field` is 1'b0 in bit 0 (instruction bit 21), and rotates it right by `imm_field` when that bit is 1.
- R3: Function code 0x03 with `reg_field` equal to zero shifts `operand` right by `imm_field` and fills the vacated high bits with copies of `operand[31]`.
- R4: Function codes 0x04, 0x06 and 0x07 are the register-amount forms of the left, right logical and right arithmetic shifts. Their amount is `amt_reg[4:0]`, and bits [31:5] of `amt_reg` do not change the result.
- R5: For function code 0x06, bit 0 of `imm_field` (instruction bit 6) selects rotate right (1) or logical right shift (0).
- R6: A rotate right by n returns (x << (32-n)) | (x >> n) for n from 1 to 31, and returns x unchanged for n = 0.
- R7: Every accepted operation whose effective amount is zero returns `operand` unchanged.
- R8: The mode field is `reg_field` for the immediate forms and `imm_field` for the register forms. A nonzero value in bits [4:1] of the mode field of codes 0x02/0x06, or any nonzero value in the mode field of codes 0x00, 0x03, 0x04 and 0x07, sets `illegal`.
- R9: Function codes 0x01 and 0x05, and any code with bits [5:3] not all zero, set `illegal`.
- R10: Whenever `illegal` is set, `result` is zero. Whenever an encoding is accepted, `illegal` is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fn_code | input | 6 | Function code of the shift instruction |
| imm_field | input | 5 | Instruction bits [10:6]: immediate amount, or the mode field of the register forms |
| reg_field | input | 5 | Instruction bits [25:21]: mode field of the immediate forms |
| amt_reg | input | 32 | Register value whose low five bits give the variable amount |
| operand | input | 32 | Value to be shifted or rotated |
| result | output | 32 | Shifted or rotated value, zero on an illegal encoding |
| illegal | output | 1 | Set when the encoding is not accepted |

## Verification
The hardest cases to reach are the mode-field corners. A uniformly random five-bit field is almost always nonzero, so random stimulus would mostly exercise the illegal path and rarely reach a legal shift. The stimulus therefore biases each mode field: most of the time it is zero, sometimes only the rotate bit is set, and the rest of the time it is random. It also fills the upper bits of `amt_reg` with random data, so that ignoring them is checked on almost every register-form vector. Directed vectors cover rotates by 0, 1 and 31, sign fill on negative operands, and each illegal function code.

// File: rtl/shrot_pkg.sv
// Shared types for the shift/rotate unit.
// Assumes a power-of-two data width no smaller than 2.
package shrot_pkg;

    typedef enum logic [1:0] {
        SK_LEFT  = 2'd0,
        SK_RLOG  = 2'd1,
        SK_RARI  = 2'd2,
        SK_ROTR  = 2'd3
    } shift_kind_e;

endpackage

// File: rtl/shrot_decode.sv
// Decodes a function code and the two instruction fields into an operation
// kind, an effective amount and an illegal flag.
// Assumes the caller only routes shift-group codes here. Others are flagged.
module shrot_decode
    import shrot_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int FIELD_W = 5,
    parameter int FN_W    = 6,
    localparam int AMT_W  = $clog2(DATA_W)
) (
    input  logic [FN_W-1:0]    fn_code,
    input  logic [FIELD_W-1:0] imm_field,
    input  logic [FIELD_W-1:0] reg_field,
    input  logic [DATA_W-1:0]  amt_reg,
    output shift_kind_e        kind,
    output logic [AMT_W-1:0]   amount,
    output logic               bad
);

    logic               var_form;
    logic [FIELD_W-1:0] mode_fld;
    logic               group_ok;

    // Pick the amount source and the mode field from the form bit.
    always_comb begin
        var_form = fn_code[2];
        group_ok = (fn_code[FN_W-1:3] == '0);
        mode_fld = var_form ? imm_field : reg_field;
        amount   = var_form ? amt_reg[AMT_W-1:0] : imm_field[AMT_W-1:0];
    end

    // Map the low function bits to a kind and check the mode field.
    always_comb begin
        kind = SK_LEFT;
        bad  = 1'b0;
        unique case (fn_code[1:0])
            2'b00: begin
                kind = SK_LEFT;
                bad  = |mode_fld;
            end
            2'b01: begin
                bad  = 1'b1;
            end
            2'b10: begin
                kind = mode_fld[0] ? SK_ROTR : SK_RLOG;
                bad  = |mode_fld[FIELD_W-1:1];
            end
            default: begin
                kind = SK_RARI;
                bad  = |mode_fld;
            end
        endcase
        if (!group_ok) bad = 1'b1;
    end

endmodule

// File: rtl/shrot_barrel.sv
// Logarithmic barrel shifter. It does right shifts with zero or sign fill,
// and rotate right. A left shift is done by reversing the bits around the
// right-shift chain. A zero amount passes every stage straight through, so
// no stage ever shifts by the full width.
module shrot_barrel
    import shrot_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int AMT_W = $clog2(DATA_W)
) (
    input  shift_kind_e       kind,
    input  logic [AMT_W-1:0]  amount,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    logic              left;
    logic              wrap;
    logic              fill;
    logic [DATA_W-1:0] rev_in;
    logic [DATA_W-1:0] rev_out;
    logic [DATA_W-1:0] stg [AMT_W+1];

    // Work out the direction, the wrap mode and the fill bit.
    always_comb begin
        left = (kind == SK_LEFT);
        wrap = (kind == SK_ROTR);
        fill = (kind == SK_RARI) & din[DATA_W-1];
    end

    // Bit-reverse the input for left shifts.
    for (genvar b = 0; b < DATA_W; b++) begin : g_rev_in
        assign rev_in[b] = din[DATA_W-1-b];
    end

    assign stg[0] = left ? rev_in : din;

    // One stage per amount bit: stage k moves by 2**k when that bit is set.
    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        localparam int S = 1 << k;
        logic [DATA_W-1:0] moved;
        always_comb begin
            if (wrap) moved = {stg[k][S-1:0], stg[k][DATA_W-1:S]};
            else      moved = {{S{fill}}, stg[k][DATA_W-1:S]};
        end
        assign stg[k+1] = amount[k] ? moved : stg[k];
    end

    // Undo the reversal for left shifts.
    for (genvar b = 0; b < DATA_W; b++) begin : g_rev_out
        assign rev_out[b] = stg[AMT_W][DATA_W-1-b];
    end

    assign dout = left ? rev_out : stg[AMT_W];

endmodule

// File: rtl/shrot_unit.sv
// Top level of the combinational shift/rotate unit: decode, barrel, then
// zeroing of the result on an illegal encoding.
// Assumes the amount register's low $clog2(DATA_W) bits carry the amount.
module shrot_unit
    import shrot_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int FIELD_W = 5,
    parameter int FN_W    = 6,
    localparam int AMT_W  = $clog2(DATA_W)
) (
    input  logic [FN_W-1:0]    fn_code,
    input  logic [FIELD_W-1:0] imm_field,
    input  logic [FIELD_W-1:0] reg_field,
    input  logic [DATA_W-1:0]  amt_reg,
    input  logic [DATA_W-1:0]  operand,
    output logic [DATA_W-1:0]  result,
    output logic               illegal
);

    shift_kind_e       kind;
    logic [AMT_W-1:0]  amount;
    logic              bad;
    logic [DATA_W-1:0] shifted;

    shrot_decode #(
        .DATA_W (DATA_W),
        .FIELD_W(FIELD_W),
        .FN_W   (FN_W)
    ) dec_i (
        .fn_code  (fn_code),
        .imm_field(imm_field),
        .reg_field(reg_field),
        .amt_reg  (amt_reg),
        .kind     (kind),
        .amount   (amount),
        .bad      (bad)
    );

    shrot_barrel #(
        .DATA_W(DATA_W)
    ) bar_i (
        .kind  (kind),
        .amount(amount),
        .din   (operand),
        .dout  (shifted)
    );

    // Force a zero result for encodings that are not accepted.
    always_comb begin
        illegal = bad;
        result  = bad ? '0 : shifted;
    end

endmodule

// File: rtl/shrot_unit_chk.sv
// Checker for the shift/rotate unit, bound to every instance of it.
// Uses immediate assertions only, because the unit has no clock.
module shrot_unit_chk #(
    parameter int DATA_W = 32
) (
    input logic [5:0]        fn_code,
    input logic [4:0]        imm_field,
    input logic [4:0]        reg_field,
    input logic [DATA_W-1:0] amt_reg,
    input logic [DATA_W-1:0] operand,
    input logic [DATA_W-1:0] result,
    input logic              illegal
);

    logic [4:0] eff_amt;
    logic       rot_sel;

    // Rebuild the effective amount and the rotate bit from the ports.
    always_comb begin
        eff_amt = fn_code[2] ? amt_reg[4:0] : imm_field;
        rot_sel = fn_code[2] ? imm_field[0] : reg_field[0];
    end

    // Property checks on the ports.
    always_comb begin
        if (!$isunknown({fn_code, imm_field, reg_field, amt_reg, operand})) begin
            a_r10_zero_when_illegal: assert (!illegal || result == '0);
            a_r9_bad_codes_flagged: assert (!(fn_code[1:0] == 2'b01) || illegal);
            a_r7_zero_amount_passes: assert (illegal || eff_amt != 5'd0 || result == operand);
            a_r3_sign_kept: assert (illegal || fn_code[1:0] != 2'b11 || result[DATA_W-1] == operand[DATA_W-1]);
            a_r1_low_bit_zero: assert (illegal || fn_code[1:0] != 2'b00 || eff_amt == 5'd0 || result[0] == 1'b0);
            a_r6_rotate_keeps_ones: assert (illegal || fn_code[1:0] != 2'b10 || !rot_sel || $countones(result) == $countones(operand));
            a_r2_top_bit_clear: assert (illegal || fn_code[1:0] != 2'b10 || rot_sel || eff_amt == 5'd0 || result[DATA_W-1] == 1'b0);
        end
    end

endmodule

bind shrot_unit shrot_unit_chk #(.DATA_W(DATA_W)) chk_i (
    .fn_code  (fn_code),
    .imm_field(imm_field),
    .reg_field(reg_field),
    .amt_reg  (amt_reg),
    .operand  (operand),
    .result   (result),
    .illegal  (illegal)
);

// File: tb/shrot_unit_tb_top.sv
// Bench for the shift/rotate unit: directed corners plus seeded random
// vectors, compared with a reference model written from the requirements.
module shrot_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  fn_code = '0;
    logic [4:0]  imm_field = '0;
    logic [4:0]  reg_field = '0;
    logic [31:0] amt_reg = '0;
    logic [31:0] operand = '0;
    logic [31:0] result;
    logic        illegal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    shrot_unit dut_i (
        .fn_code  (fn_code),
        .imm_field(imm_field),
        .reg_field(reg_field),
        .amt_reg  (amt_reg),
        .operand  (operand),
        .result   (result),
        .illegal  (illegal)
    );

    // Reference: returns {illegal, result}.
    function automatic logic [32:0] model(input logic [5:0] f, input logic [4:0] imf,
                                          input logic [4:0] rgf, input logic [31:0] ar,
                                          input logic [31:0] x);
        logic [4:0]  mode;
        logic [4:0]  n;
        logic [31:0] r;
        mode = f[2] ? imf : rgf;
        n    = f[2] ? ar[4:0] : imf;
        if (f[5:3] != 3'b000 || f[1:0] == 2'b01) return 33'h1_0000_0000;
        case (f[1:0])
            2'b00: begin
                if (mode != 5'd0) return 33'h1_0000_0000;
                r = x << n;
            end
            2'b10: begin
                if (mode[4:1] != 4'd0) return 33'h1_0000_0000;
                if (mode[0]) r = (n == 5'd0) ? x : ((x << (6'd32 - {1'b0, n})) | (x >> n));
                else         r = x >> n;
            end
            default: begin
                if (mode != 5'd0) return 33'h1_0000_0000;
                r = 32'($signed(x) >>> n);
            end
        endcase
        return {1'b0, r};
    endfunction

    // Name the requirement that a vector mainly exercises.
    function automatic string req_of(input logic [5:0] f, input logic [32:0] e,
                                     input logic [4:0] imf, input logic [4:0] rgf);
        if (f[5:3] != 3'b000 || f[1:0] == 2'b01) return "R9";
        if (e[32]) return "R8";
        if (f == 6'h00) return "R1";
        if (f == 6'h02) return rgf[0] ? "R6" : "R2";
        if (f == 6'h03) return "R3";
        if (f == 6'h06) return imf[0] ? "R5" : "R4";
        return "R4";
    endfunction

    // Drive one vector on the rising edge, then check it at the falling edge.
    task automatic apply(input logic [5:0] f, input logic [4:0] imf, input logic [4:0] rgf,
                         input logic [31:0] ar, input logic [31:0] x, input string tag);
        logic [32:0] exp_v;
        @(posedge clk);
        fn_code = f; imm_field = imf; reg_field = rgf; amt_reg = ar; operand = x;
        @(negedge clk);
        exp_v = model(f, imf, rgf, ar, x);
        checks++;
        if ({illegal, result} !== exp_v) begin
            errors++;
            $display("FAIL %s fn=%h imm=%h reg=%h amt=%h op=%h got ill=%b res=%h exp ill=%b res=%h",
                     (tag == "") ? req_of(f, exp_v, imf, rgf) : tag, f, imf, rgf, ar, x,
                     illegal, result, exp_v[32], exp_v[31:0]);
        end
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [5:0] fsel [6];
        fsel = '{6'h00, 6'h02, 6'h03, 6'h04, 6'h06, 6'h07};
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle state after reset: all-zero inputs give zero and no flag (R10).
        @(negedge clk);
        checks++;
        if (result !== 32'h0 || illegal !== 1'b0) begin
            errors++;
            $display("FAIL R10 idle got ill=%b res=%h exp ill=0 res=0", illegal, result);
        end
        // R1 left shift corners.
        apply(6'h00, 5'd4, 5'd0, 32'h0, 32'h8000_000F, "R1");
        apply(6'h00, 5'd31, 5'd0, 32'h0, 32'hFFFF_FFFF, "R1");
        // R2 logical right and rotate select.
        apply(6'h02, 5'd8, 5'd0, 32'h0, 32'hF000_00FF, "R2");
        apply(6'h02, 5'd8, 5'd1, 32'h0, 32'hF000_00FF, "R2");
        // R6 rotate by 0, 1 and 31.
        apply(6'h02, 5'd0, 5'd1, 32'h0, 32'h1234_5678, "R6");
        apply(6'h02, 5'd1, 5'd1, 32'h0, 32'h0000_0001, "R6");
        apply(6'h02, 5'd31, 5'd1, 32'h0, 32'h8000_0000, "R6");
        // R3 sign fill on a negative operand.
        apply(6'h03, 5'd31, 5'd0, 32'h0, 32'h8000_0000, "R3");
        apply(6'h03, 5'd4, 5'd0, 32'h0, 32'h7000_0000, "R3");
        // R4 upper amount bits ignored.
        apply(6'h04, 5'd0, 5'd0, 32'hFFFF_FFE3, 32'h0000_0001, "R4");
        apply(6'h07, 5'd0, 5'd0, 32'hABCD_0010, 32'h8000_0000, "R4");
        // R5 variable rotate, select in the amount field.
        apply(6'h06, 5'd1, 5'd0, 32'h0000_0004, 32'h0000_000F, "R5");
        apply(6'h06, 5'd0, 5'd0, 32'h0000_0004, 32'h0000_000F, "R5");
        // R7 zero amount passes the operand through.
        apply(6'h03, 5'd0, 5'd0, 32'h0, 32'hDEAD_BEEF, "R7");
        apply(6'h04, 5'd0, 5'd0, 32'hFFFF_FFE0, 32'hCAFE_F00D, "R7");
        // R8 reserved mode bits.
        apply(6'h02, 5'd3, 5'd2, 32'h0, 32'hFFFF_FFFF, "R8");
        apply(6'h00, 5'd3, 5'd1, 32'h0, 32'hFFFF_FFFF, "R8");
        apply(6'h07, 5'd1, 5'd0, 32'h3, 32'hFFFF_FFFF, "R8");
        // R9 codes outside the accepted set.
        apply(6'h01, 5'd3, 5'd0, 32'h0, 32'hFFFF_FFFF, "R9");
        apply(6'h05, 5'd0, 5'd0, 32'h3, 32'hFFFF_FFFF, "R9");
        apply(6'h0A, 5'd3, 5'd0, 32'h0, 32'hFFFF_FFFF, "R9");
        // Random vectors with biased mode fields.
        for (int i = 0; i < 4000; i++) begin
            logic [5:0] f;
            logic [4:0] imf;
            logic [4:0] rgf;
            int pick;
            pick = int'($urandom_range(0, 19));
            f    = (pick < 18) ? fsel[pick % 6] : 6'($urandom);
            imf  = 5'($urandom);
            rgf  = 5'($urandom);
            case ($urandom_range(0, 9))
                0, 1, 2, 3, 4: begin if (f[2]) imf = 5'd0; else rgf = 5'd0; end
                5, 6, 7:       begin if (f[2]) imf = 5'd1; else rgf = 5'd1; end
                default: ;
            endcase
            apply(f, imf, rgf, $urandom, $urandom, "");
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule